// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs the digital side of a successive-approximation analog-to-digital conversion. A start pulse sent while the block is idle switches the external track/hold into hold. The block then waits a fixed number of clock cycles so the held voltage can settle, and clears its approximation register. It then tests one bit per clock cycle, from the most significant bit down, by driving a trial code to an external DAC. In each cycle it reads a one-bit comparator verdict that says whether the DAC output is above the held input.

When the sampling input `short_i` is high on the start cycle, the sequencer runs a short conversion. This tests only the upper `SHORT_WIDTH` bits and leaves the lower bits at zero. When the last bit has been decided, the block does four things: it pulses end-of-conversion together with a flag giving the length that finished, it stops the bit clock, it returns the track/hold to sample, and it places the code in a result register. That register keeps its value until the next conversion finishes. A conversion in progress cannot be cancelled or restarted.

The controller has four states. IDLE moves to SETTLE when a start is seen. SETTLE moves to TRIAL when the settle timer expires. TRIAL moves to DONE on the last bit, which is bit 0 for a full cycle and bit `WIDTH-SHORT_WIDTH` for a short cycle. DONE always moves back to IDLE after one cycle.

Top module: `sar_sequencer`

## Requirements
- R1: After reset, `hold_o`, `bitclk_en_o`, `busy_o`, `eoc_o` and `eoc_short_o` are low, and `result_o` and `dac_code_o` are zero.
- R2: When `start_i` is high in IDLE, `hold_o` and `busy_o` are high from the next cycle on. `dac_code_o` reads zero while the block settles, because the approximation register has been cleared.
- R3: For `SETTLE_CYCLES` cycles after a start, `bitclk_en_o` stays low and no bit is tested. In the cycle after that, `bitclk_en_o` is high and `dac_code_o` has only its most significant bit set.
- R4: One bit is tested per cycle, from MSB to LSB. `dac_code_o` is the bits kept so far plus the bit under test. At the end of the cycle, `cmp_i` = 1 (DAC above input) clears that bit and `cmp_i` = 0 keeps it. For a comparator that reports code > input, the result of a full conversion equals the input code.
- R5: If `short_i` is high on the start cycle, only the upper `SHORT_WIDTH` bits are tested, and the low `WIDTH-SHORT_WIDTH` result bits are zero.
- R6: The conversion length is captured on the start cycle. Changes on `short_i` during a conversion have no effect.
- R7: A `start_i` pulse while a conversion is running is ignored. The running conversion keeps its timing and its result.
- R8: `eoc_o` is a one-cycle pulse. It appears `SETTLE_CYCLES + N + 1` cycles after the start edge, where N is `WIDTH` or `SHORT_WIDTH`. In that cycle `eoc_short_o` shows the length that completed, and `hold_o` and `bitclk_en_o` are low.
- R9: `result_o` changes only in the cycle where `eoc_o` is high, and it otherwise holds its value whatever the comparator does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, sampled in IDLE |
| short_i | input | 1 | Length select sampled at start: 0 full, 1 short |
| cmp_i | input | 1 | Comparator verdict: 1 when the DAC output is above the held input |
| hold_o | output | 1 | Track/hold control: 1 hold, 0 sample |
| bitclk_en_o | output | 1 | High while bit trials run |
| busy_o | output | 1 | High from start until end-of-conversion |
| dac_code_o | output | WIDTH | Trial code for the external DAC |
| eoc_o | output | 1 | End-of-conversion pulse |
| eoc_short_o | output | 1 | With `eoc_o`: the finished conversion was short |
| result_o | output | WIDTH | Last completed conversion code |

## Verification
The bench builds the block with `WIDTH` = 8, `SHORT_WIDTH` = 5 and `SETTLE_CYCLES` = 3. With these values every input code from 0 to 255 can be converted in both lengths, and each conversion checks its latency to the cycle. The comparator is modelled arithmetically in the bench, so the expected results are the input code itself and the input code with its low three bits cleared. Every seventh conversion also sees a stray start pulse and a flipped length select in mid-cycle. After each conversion the bench moves the input to a new value, to show that the held result does not change.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_TRIAL  = 2'd2,
        ST_DONE   = 2'd3
    } sar_state_e;

endpackage

// File: rtl/sar_settle_timer.sv
module sar_settle_timer #(
    parameter int SETTLE_CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int CW = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES);
    localparam logic [CW-1:0] RELOAD = CW'(SETTLE_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= RELOAD;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
    parameter int WIDTH       = 12,
    parameter int SHORT_WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             trial_i,
    input  logic             short_i,
    input  logic             cmp_i,
    output logic             last_o,
    output logic [WIDTH-1:0] dac_code_o,
    output logic [WIDTH-1:0] result_o
);
    localparam int LOW_BITS = WIDTH - SHORT_WIDTH;
    localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

    logic [WIDTH-1:0] kept_q;
    logic [WIDTH-1:0] probe_q;
    logic [WIDTH-1:0] kept_d;
    logic [WIDTH-1:0] keep_mask;
    logic [WIDTH-1:0] result_q;

    generate
        if (LOW_BITS > 0) begin : g_short_mask
            assign keep_mask = short_i ? {{SHORT_WIDTH{1'b1}}, {LOW_BITS{1'b0}}} : '1;
            assign last_o    = short_i ? probe_q[LOW_BITS] : probe_q[0];
        end else begin : g_no_short
            assign keep_mask = '1;
            assign last_o    = probe_q[0];
        end
    endgenerate

    // A set comparator verdict drops the bit under test; otherwise it is kept.
    assign kept_d = cmp_i ? kept_q : (kept_q | probe_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kept_q  <= '0;
            probe_q <= '0;
        end else if (clear_i) begin
            kept_q  <= '0;
            probe_q <= TOP_BIT;
        end else if (trial_i) begin
            kept_q  <= kept_d;
            probe_q <= probe_q >> 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (trial_i && last_o) begin
            result_q <= kept_d & keep_mask;
        end
    end

    assign dac_code_o = trial_i ? (kept_q | probe_q) : kept_q;
    assign result_o   = result_q;
endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
    import sar_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic short_i,
    input  logic settle_done_i,
    input  logic last_bit_i,
    output logic short_q_o,
    output logic clear_o,
    output logic timer_load_o,
    output logic timer_run_o,
    output logic trial_o,
    output logic hold_o,
    output logic bitclk_en_o,
    output logic busy_o,
    output logic eoc_o,
    output logic eoc_short_o
);
    sar_state_e state_q, state_d;
    logic       short_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            short_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i) begin
                short_q <= short_i;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i)       state_d = ST_SETTLE;
            ST_SETTLE: if (settle_done_i) state_d = ST_TRIAL;
            ST_TRIAL:  if (last_bit_i)    state_d = ST_DONE;
            ST_DONE:                      state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        clear_o      = 1'b0;
        timer_load_o = 1'b0;
        timer_run_o  = 1'b0;
        trial_o      = 1'b0;
        hold_o       = 1'b0;
        bitclk_en_o  = 1'b0;
        busy_o       = 1'b0;
        eoc_o        = 1'b0;
        eoc_short_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                clear_o      = start_i;
                timer_load_o = start_i;
            end
            ST_SETTLE: begin
                hold_o      = 1'b1;
                busy_o      = 1'b1;
                timer_run_o = 1'b1;
            end
            ST_TRIAL: begin
                hold_o      = 1'b1;
                busy_o      = 1'b1;
                bitclk_en_o = 1'b1;
                trial_o     = 1'b1;
            end
            ST_DONE: begin
                busy_o      = 1'b1;
                eoc_o       = 1'b1;
                eoc_short_o = short_q;
            end
            default: ;
        endcase
    end

    assign short_q_o = short_q;
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
    parameter int WIDTH         = 12,
    parameter int SHORT_WIDTH   = 8,
    parameter int SETTLE_CYCLES = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             short_i,
    input  logic             cmp_i,
    output logic             hold_o,
    output logic             bitclk_en_o,
    output logic             busy_o,
    output logic [WIDTH-1:0] dac_code_o,
    output logic             eoc_o,
    output logic             eoc_short_o,
    output logic [WIDTH-1:0] result_o
);
    logic short_q;
    logic clear;
    logic timer_load;
    logic timer_run;
    logic trial;
    logic settle_done;
    logic last_bit;

    sar_seq_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .short_i       (short_i),
        .settle_done_i (settle_done),
        .last_bit_i    (last_bit),
        .short_q_o     (short_q),
        .clear_o       (clear),
        .timer_load_o  (timer_load),
        .timer_run_o   (timer_run),
        .trial_o       (trial),
        .hold_o        (hold_o),
        .bitclk_en_o   (bitclk_en_o),
        .busy_o        (busy_o),
        .eoc_o         (eoc_o),
        .eoc_short_o   (eoc_short_o)
    );

    sar_settle_timer #(
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (timer_load),
        .run_i     (timer_run),
        .expired_o (settle_done)
    );

    sar_approx_reg #(
        .WIDTH       (WIDTH),
        .SHORT_WIDTH (SHORT_WIDTH)
    ) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear),
        .trial_i    (trial),
        .short_i    (short_q),
        .cmp_i      (cmp_i),
        .last_o     (last_bit),
        .dac_code_o (dac_code_o),
        .result_o   (result_o)
    );
endmodule

// File: rtl/sar_sequencer_chk.sv
module sar_sequencer_chk #(
    parameter int WIDTH       = 12,
    parameter int SHORT_WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             hold_o,
    input logic             bitclk_en_o,
    input logic             busy_o,
    input logic [WIDTH-1:0] dac_code_o,
    input logic             eoc_o,
    input logic             eoc_short_o,
    input logic [WIDTH-1:0] result_o
);
    localparam int LOW_BITS = WIDTH - SHORT_WIDTH;

    AST_HOLD_DURING_TRIALS: assert property (@(posedge clk) disable iff (!rst_n)
        bitclk_en_o |-> hold_o); // R2

    AST_SETTLE_CODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_o && !bitclk_en_o) |-> (dac_code_o == '0)); // R2

    AST_TRIAL_HAS_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
        bitclk_en_o |-> (dac_code_o != '0)); // R4

    AST_EOC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_o |=> !eoc_o); // R8

    AST_EOC_RELEASES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_o |-> (!hold_o && !bitclk_en_o)); // R8

    AST_BUSY_NOT_ABORTED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !eoc_o) |=> busy_o); // R7

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !eoc_o |-> $stable(result_o)); // R9

    AST_SHORT_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc_o && eoc_short_o) |-> (result_o[LOW_BITS-1:0] == '0)); // R5

    AST_SHORT_FLAG_ONLY_AT_EOC: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_short_o |-> eoc_o); // R8
endmodule

bind sar_sequencer sar_sequencer_chk #(
    .WIDTH       (WIDTH),
    .SHORT_WIDTH (SHORT_WIDTH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .hold_o      (hold_o),
    .bitclk_en_o (bitclk_en_o),
    .busy_o      (busy_o),
    .dac_code_o  (dac_code_o),
    .eoc_o       (eoc_o),
    .eoc_short_o (eoc_short_o),
    .result_o    (result_o)
);

// File: tb/tb_sar_sequencer.sv
`timescale 1ns/1ps
module tb_sar_sequencer;
    localparam int W  = 8;
    localparam int SW = 5;
    localparam int S  = 3;
    localparam int LB = W - SW;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         short_i = 1'b0;
    logic         cmp_i;
    logic         hold_o, bitclk_en_o, busy_o, eoc_o, eoc_short_o;
    logic [W-1:0] dac_code_o, result_o;
    logic [W-1:0] vin = '0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    // Comparator model: high when the DAC code is above the input code.
    assign cmp_i = (dac_code_o > vin);

    sar_sequencer #(.WIDTH(W), .SHORT_WIDTH(SW), .SETTLE_CYCLES(S)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .short_i(short_i),
        .cmp_i(cmp_i), .hold_o(hold_o), .bitclk_en_o(bitclk_en_o),
        .busy_o(busy_o), .dac_code_o(dac_code_o), .eoc_o(eoc_o),
        .eoc_short_o(eoc_short_o), .result_o(result_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    task automatic convert(input int v, input bit short_mode, input bit disturb);
        int n;
        int k;
        logic [W-1:0] exp_res;
        logic [W-1:0] held;
        n = short_mode ? SW : W;
        exp_res = short_mode ? (W'(v) & ~W'((1 << LB) - 1)) : W'(v);
        vin = W'(v);
        start_i = 1'b1;
        short_i = short_mode;
        @(negedge clk);
        start_i = 1'b0;
        k = 1;
        check("R2 hold", {31'd0, hold_o}, 32'd1);
        check("R2 clear", {24'd0, dac_code_o}, 32'd0);
        while (!eoc_o && k < 64) begin
            if (k <= S) check("R3 settle", {31'd0, bitclk_en_o}, 32'd0);
            if (k == S + 1) check("R3 first trial", {24'd0, dac_code_o}, 32'(1 << (W - 1)));
            if (disturb && k == S + 2) begin
                start_i = 1'b1;            // R7 stray start
                short_i = ~short_mode;     // R6 length flip
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            k++;
        end
        start_i = 1'b0;
        short_i = short_mode;
        check("R8 latency", 32'(k), 32'(S + n + 1));
        check("R8 length flag", {31'd0, eoc_short_o}, {31'd0, short_mode});
        check("R8 hold released", {30'd0, hold_o, bitclk_en_o}, 32'd0);
        check(short_mode ? "R5 short result" : "R4 full result", {24'd0, result_o}, {24'd0, exp_res});
        if (disturb) check("R6 R7 disturbed result", {24'd0, result_o}, {24'd0, exp_res});
        held = result_o;
        vin = ~W'(v);
        repeat (3) @(negedge clk);
        check("R9 result held", {24'd0, result_o}, {24'd0, held});
        check("R8 eoc pulse", {31'd0, eoc_o}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 hold", {31'd0, hold_o}, 32'd0);
        check("R1 flags", {28'd0, bitclk_en_o, busy_o, eoc_o, eoc_short_o}, 32'd0);
        check("R1 result", {24'd0, result_o}, 32'd0);
        check("R1 dac", {24'd0, dac_code_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int v = 0; v < (1 << W); v++) begin
            convert(v, 1'b0, (v % 7) == 3);
            convert(v, 1'b1, (v % 7) == 5);
        end
        finish_run();
    end
endmodule